// File: doc/BRIEF.md
# Page-Mode External Bus Cycle Sequencer

This block runs the external memory bus cycles of a small byte-oriented controller. The bus is multiplexed and page-mode. A requester offers an access: an instruction fetch, a data read or a data write. When the block is idle it takes the access and compares the high address byte with the page it last put on the bus. A page miss costs four phases. The first two phases re-issue the high byte on the upper port, and the first phase also pulses the address latch enable. A page hit skips the address phases and costs two phases. All timing counts system clocks, and one phase is one system clock.

Data accesses can be slowed with a 3-bit stretch code. Each stretch cycle adds four system clocks to the access. The read or write strobe widens with the code, following its own non-linear table, and it always ends on the final phase. The stretch code is frozen when the access is accepted. The final phase raises a one-clock done pulse, and the read data is captured at the end of that phase. Converting the strobe width to oscillator clocks is left to the integrator: multiply by 0.25 in 4X mode, by 0.5 in 2X mode and by 1 in divide-by-1 mode.

Top module: `pgbus_seq`

## Requirements
- R1: After reset the block is ready. The program store strobe and both read/write strobes are high, and the address latch enable and done are low. The page record is empty, so the first access is a page miss.
- R2: A fetch that misses lasts 4 clocks. The address latch enable is high only in clock 0, and the program store strobe is low in clocks 2 and 3 only.
- R3: A fetch whose high address byte equals the last recorded page lasts 2 clocks. The address latch enable stays low, and the program store strobe is low in both clocks.
- R4: On a miss, the upper port is driven (enable high) with the high address byte in clocks 0 and 1. For fetches and reads, the upper port is not driven in any other clock, so a hit never re-issues the high address.
- R5: The lower port carries the low address byte in every clock of every access.
- R6: A data access lasts (2 if hit, 4 if miss) + 4·S clocks. The stretch code maps to S as 0→0, 1→1, 2→2, 3→3, 4→7, 5→8, 6→9, 7→10.
- R7: In a data access, the read strobe (for a read) or the write strobe (for a write) is low for exactly the final W clocks. The code maps to W as 0→1, 1→3, 2→7, 3→11, 4→15, 5→19, 6→23, 7→27. At most one strobe is low at any time.
- R8: In a write, the upper port is driven with the write data in every clock outside the address phases.
- R9: Done is high for exactly the final clock of an access. From the next clock, the block is ready again, and for fetches and reads the data output holds the value present on the bus input in that final clock.
- R10: Ready is low while an access is in progress. A request held high during that time has no effect on the access, nor on the recorded page.
- R11: The stretch code is sampled when a data access is accepted. Changing the code during the access does not change its length or its strobe width.
- R12: Every accepted access (fetch, read or write) records its high address byte as the current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, taken while ready_o is high |
| req_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| req_write_i | input | 1 | 1 = write (data accesses only) |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write data |
| req_code_i | input | 3 | Stretch code for data accesses |
| bus_in_i | input | 8 | Data returned by the external memory |
| ready_o | output | 1 | Idle, able to accept a request |
| done_o | output | 1 | Final phase of the current access |
| rdata_o | output | 8 | Data captured in the last final phase |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| lo_port_o | output | 8 | Low address byte |
| hi_port_o | output | 8 | High address byte or write data |
| hi_oe_o | output | 1 | Upper port drive enable |

## Verification
The assertions assume that the request fields are meaningful only on the clock edge where a request meets ready. They also assume that requests and stretch codes may change freely while an access is in progress. The stimulus exercises both assumptions on purpose. It changes to a new address page and inverts the stretch code in the first busy clock, and it keeps the request high until the clock after done. Beyond that, the stimulus raises a request only when ready is high. It sweeps all eight stretch codes through both miss and hit orderings for reads, writes and fetches.

// File: rtl/pgbus_pkg.sv
package pgbus_pkg;

  localparam int CODE_W       = 3;
  localparam int STRETCH_CLKS = 4;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } acc_kind_e;

  // Stretch machine cycles: the upper half of the code range jumps by three.
  function automatic int stretch_cycles(input logic [CODE_W-1:0] code);
    return code[CODE_W-1] ? int'(code) + 3 : int'(code);
  endfunction

  // Strobe width in system clocks: one clock at code zero, else one short
  // of a whole number of stretch cycles.
  function automatic int strobe_clocks(input logic [CODE_W-1:0] code);
    return (code == '0) ? 1 : STRETCH_CLKS * int'(code) - 1;
  endfunction

endpackage

// File: rtl/pgbus_page_tracker.sv
module pgbus_page_tracker #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);

  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (update_i) begin
      valid_q <= 1'b1;
      page_q  <= page_i;
    end
  end

  assign hit_o = valid_q && (page_q == page_i);

endmodule

// File: rtl/pgbus_phase_ctr.sv
module pgbus_phase_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] rem_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic             active_o,
  output logic             last_o
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] el_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      el_q  <= '0;
    end else if (load_i) begin
      rem_q <= len_i;
      el_q  <= '0;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - CNT_W'(1);
      el_q  <= el_q + CNT_W'(1);
    end
  end

  assign rem_o     = rem_q;
  assign elapsed_o = el_q;
  assign active_o  = (rem_q != '0);
  assign last_o    = (rem_q == CNT_W'(1));

endmodule

// File: rtl/pgbus_seq.sv
module pgbus_seq
  import pgbus_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MISS_PHASES  = 4,
  parameter int HIT_PHASES   = 2,
  parameter int ADDR_PHASES  = 2,
  parameter int FETCH_STROBE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic                  req_data_i,
  input  logic                  req_write_i,
  input  logic [2*DATA_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic [CODE_W-1:0]     req_code_i,
  input  logic [DATA_W-1:0]     bus_in_i,
  output logic                  ready_o,
  output logic                  done_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  ale_o,
  output logic                  psen_n_o,
  output logic                  rd_n_o,
  output logic                  wr_n_o,
  output logic [DATA_W-1:0]     lo_port_o,
  output logic [DATA_W-1:0]     hi_port_o,
  output logic                  hi_oe_o
);

  localparam int ADDR_W  = 2 * DATA_W;
  localparam int MAX_LEN = MISS_PHASES + STRETCH_CLKS * stretch_cycles('1);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  // Named internal events, also used by the bound checker.
  logic              accept;
  logic              busy;
  logic              last;
  logic              hit_now;
  logic              strobe_on;
  logic              addr_phase;

  acc_kind_e         kind_now, kind_q;
  logic              hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  len_now, width_cur, rem, elapsed;

  assign accept   = req_i && !busy;
  assign kind_now = !req_data_i ? K_FETCH : (req_write_i ? K_WRITE : K_READ);

  pgbus_page_tracker #(.PAGE_W(DATA_W)) page_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .update_i (accept),
    .page_i   (req_addr_i[ADDR_W-1:DATA_W]),
    .hit_o    (hit_now)
  );

  assign len_now = CNT_W'((hit_now ? HIT_PHASES : MISS_PHASES)
                   + ((kind_now == K_FETCH) ? 0
                      : STRETCH_CLKS * stretch_cycles(req_code_i)));

  pgbus_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .len_i     (len_now),
    .rem_o     (rem),
    .elapsed_o (elapsed),
    .active_o  (busy),
    .last_o    (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= K_FETCH;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      code_q  <= '0;
    end else if (accept) begin
      kind_q  <= kind_now;
      hit_q   <= hit_now;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      code_q  <= req_code_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (last && kind_q != K_WRITE) begin
      rdata_q <= bus_in_i;
    end
  end

  // Strobe width follows the frozen code; fetches use a fixed width.
  assign width_cur  = (kind_q == K_FETCH) ? CNT_W'(FETCH_STROBE)
                                          : CNT_W'(strobe_clocks(code_q));
  assign strobe_on  = busy && (rem <= width_cur);
  assign addr_phase = busy && !hit_q && (elapsed < CNT_W'(ADDR_PHASES));

  assign ready_o   = !busy;
  assign done_o    = last;
  assign rdata_o   = rdata_q;
  assign ale_o     = busy && !hit_q && (elapsed == '0);
  assign psen_n_o  = !(strobe_on && kind_q == K_FETCH);
  assign rd_n_o    = !(strobe_on && kind_q == K_READ);
  assign wr_n_o    = !(strobe_on && kind_q == K_WRITE);
  assign lo_port_o = addr_q[DATA_W-1:0];
  assign hi_port_o = addr_phase ? addr_q[ADDR_W-1:DATA_W] : wdata_q;
  assign hi_oe_o   = addr_phase || (busy && kind_q == K_WRITE);

endmodule

// File: rtl/pgbus_seq_chk.sv
module pgbus_seq_chk #(
  parameter int CODE_W = pgbus_pkg::CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_o,
  input logic              done_o,
  input logic              ale_o,
  input logic              psen_n_o,
  input logic              rd_n_o,
  input logic              wr_n_o,
  input logic              busy,
  input logic              hit_q,
  input logic [CODE_W-1:0] code_q
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (psen_n_o && rd_n_o && wr_n_o && !ale_o));

  a_r2_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  a_r3_hit_no_ale: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hit_q) |-> !ale_o);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!psen_n_o, !rd_n_o, !wr_n_o}));

  a_r7_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o && !done_o) |=> !rd_n_o);

  a_r7_wr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o && !done_o) |=> !wr_n_o);

  a_r9_done_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(psen_n_o && rd_n_o && wr_n_o));

  a_r9_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> ready_o);

  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !done_o) |=> !ready_o);

  a_r11_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_o) |=> $stable(code_q));

endmodule

bind pgbus_seq pgbus_seq_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready_o  (ready_o),
  .done_o   (done_o),
  .ale_o    (ale_o),
  .psen_n_o (psen_n_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .busy     (busy),
  .hit_q    (hit_q),
  .code_q   (code_q)
);

// File: tb/pgbus_seq_tb_top.sv
module pgbus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        req_data_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic [2:0]  req_code_i = '0;
  logic [7:0]  bus_in_i = '0;
  logic        ready_o, done_o, ale_o, psen_n_o, rd_n_o, wr_n_o, hi_oe_o;
  logic [7:0]  rdata_o, lo_port_o, hi_port_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  bit         pv = 1'b0;
  logic [7:0] pp = '0;

  int stretch_tab[8] = '{0, 1, 2, 3, 7, 8, 9, 10};
  int width_tab[8]   = '{1, 3, 7, 11, 15, 19, 23, 27};

  always #4 clk = ~clk;

  pgbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_data_i(req_data_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_code_i(req_code_i), .bus_in_i(bus_in_i), .ready_o(ready_o),
    .done_o(done_o), .rdata_o(rdata_o), .ale_o(ale_o), .psen_n_o(psen_n_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .lo_port_o(lo_port_o),
    .hi_port_o(hi_port_o), .hi_oe_o(hi_oe_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  task automatic access(input bit data, input bit wr, input logic [15:0] addr,
                        input logic [2:0] code);
    bit         exp_hit;
    int         len, w, k;
    int         ale_bad, stb_bad, hi_bad, lo_bad;
    logic [7:0] wd, bv;
    string      tl, ts, th;
    exp_hit = pv && (pp == addr[15:8]);
    w   = data ? width_tab[code] : 2;
    len = (exp_hit ? 2 : 4) + (data ? 4 * stretch_tab[code] : 0);
    wd  = addr[7:0] + 8'h3C;
    bv  = addr[7:0] ^ 8'hA5 ^ {5'd0, code};
    ale_bad = 0; stb_bad = 0; hi_bad = 0; lo_bad = 0;
    if (data) begin
      tl = "R6 R11 R12"; ts = "R7";
    end else begin
      tl = exp_hit ? "R3 R12" : "R2"; ts = exp_hit ? "R3" : "R2";
    end
    th = (data && wr) ? "R8" : "R4";
    check(ready_o === 1'b1, "R10", "ready before request", ready_o, 1);
    req_i = 1'b1; req_data_i = data; req_write_i = wr; req_addr_i = addr;
    req_wdata_i = wd; req_code_i = code; bus_in_i = bv;
    @(negedge clk);
    // R10/R11: request stays high with a different page and code during the access
    req_addr_i = {8'hEE, addr[7:0]};
    req_code_i = ~code;
    pv = 1'b1; pp = addr[15:8];
    k = 0;
    forever begin
      bit ea, es, ao;
      ea = !exp_hit && k == 0;
      es = k >= len - w;
      ao = !exp_hit && k < 2;
      if (ale_o !== ea) ale_bad++;
      if (psen_n_o !== !(es && !data) || rd_n_o !== !(es && data && !wr) ||
          wr_n_o !== !(es && data && wr)) stb_bad++;
      if (hi_oe_o !== (ao || (data && wr))) hi_bad++;
      else if (ao && hi_port_o !== addr[15:8]) hi_bad++;
      else if (!ao && data && wr && hi_port_o !== wd) hi_bad++;
      if (lo_port_o !== addr[7:0]) lo_bad++;
      if (done_o === 1'b1 || k > 100) break;
      k++;
      @(negedge clk);
    end
    check(k + 1 == len, tl, "cycle length", k + 1, len);
    check(ale_bad == 0, exp_hit ? "R3" : "R2", "ALE clocks wrong", ale_bad, 0);
    check(stb_bad == 0, ts, "strobe clocks wrong", stb_bad, 0);
    check(hi_bad == 0, th, "upper port clocks wrong", hi_bad, 0);
    check(lo_bad == 0, "R5", "lower port clocks wrong", lo_bad, 0);
    @(negedge clk);
    req_i = 1'b0;
    check(ready_o === 1'b1 && done_o === 1'b0, "R9", "ready after done", ready_o, 1);
    if (!(data && wr))
      check(rdata_o === bv, "R9", "captured data", rdata_o, bv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ready_o === 1'b1, "R1", "ready in reset", ready_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o === 1'b1 && done_o === 1'b0, "R1", "ready/done after reset",
          {ready_o, done_o}, 2);
    check(psen_n_o === 1'b1 && rd_n_o === 1'b1 && wr_n_o === 1'b1, "R1",
          "strobes idle", {psen_n_o, rd_n_o, wr_n_o}, 7);
    check(ale_o === 1'b0, "R1", "ALE idle", ale_o, 0);
    // R1: first access after reset is a miss even for page 0
    access(1'b0, 1'b0, 16'h0010, 3'd0);
    access(1'b0, 1'b0, 16'h0011, 3'd5);
    access(1'b0, 1'b0, 16'h1302, 3'd0);
    for (int c = 0; c < 8; c++) begin
      logic [7:0] pg;
      pg = 8'h20 + 8'(c);
      access(1'b1, 1'b0, {pg, 8'(c * 8)}, 3'(c));
      access(1'b1, 1'b1, {pg, 8'(c * 8 + 1)}, 3'(c));
      access(1'b0, 1'b0, {pg, 8'(c * 8 + 2)}, 3'(c));
      access(1'b1, 1'b1, {pg + 8'h40, 8'(c * 8 + 3)}, 3'(7 - c));
      access(1'b1, 1'b0, {pg + 8'h40, 8'(c * 8 + 4)}, 3'(c));
    end
    // R12: a data write moves the page, so a later fetch there hits
    access(1'b1, 1'b1, 16'h5500, 3'd1);
    access(1'b0, 1'b0, 16'h5501, 3'd0);
    summary();
  end

endmodule